// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block produces the raster timing for a parallel RGB565 LCD panel. A horizontal pixel counter and a vertical line counter run from the pixel clock. Every event position is programmed as an absolute count, with the start of sync at count zero. From these counts the block drives horizontal sync, vertical sync and a display-enable strobe. It also gives the coordinates of the current active pixel and the raw line number, so that a pixel fetch engine outside the block can follow the raster.

Three sticky interrupt status bits record three moments: the start of a frame (the first line of vertical sync), the first active line, and a programmed interrupt line. Each bit is cleared by writing one to it. An enable mask decides which status bits drive the single interrupt output. The polarity of each sync output can be set on its own. The configuration inputs are expected to stay static while the counters run.

Top module: `lcd_timing_gen`

## Requirements
- R1: The horizontal count runs 0, 1, …, `cfg_h_total` and then returns to 0, so a line lasts `cfg_h_total`+1 clocks. Sync is asserted internally while the count is below `cfg_h_sync_end`.
- R2: `line_no` starts at 0 and advances by one on the clock that ends each line. After line `cfg_v_total` it returns to 0, so a frame lasts `cfg_v_total`+1 lines.
- R3: Vertical sync is asserted internally while `line_no` is below `cfg_v_sync_end`.
- R4: `de` is high exactly when the horizontal count lies in [`cfg_h_disp_start`, `cfg_h_disp_start`+`cfg_h_active`) and the line lies in [`cfg_v_disp_start`, `cfg_v_irq_line`).
- R5: While `de` is high, `px_x` equals the horizontal count minus `cfg_h_disp_start` and `px_y` equals the line minus `cfg_v_disp_start`. Both are 0 while `de` is low.
- R6: `cfg_sync_pol` bit 0 sets the polarity of `hsync` and bit 1 sets the polarity of `vsync`. A bit value of 1 gives active high and 0 gives active low, so the value 3 makes both active high.
- R7: Status bit 0 sets on the clock that follows the first pixel (count 0) of line 0.
- R8: Status bit 1 sets on the clock that follows the first pixel of line `cfg_v_disp_start`.
- R9: Status bit 2 sets on the clock that follows the first pixel of line `cfg_v_irq_line`.
- R10: Status bits stay set until a clock on which the matching `irq_clr` bit is 1. A new event on that same clock wins over the clear.
- R11: `irq` is high exactly when some status bit is set and its `irq_mask` bit is 1.
- R12: While `rst_n` is low, both counters, `irq_status` and `irq` are 0. The first clock after release starts line 0 at count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_h_sync_end | input | HW | Horizontal count at which sync ends |
| cfg_h_disp_start | input | HW | Horizontal count of the first active pixel |
| cfg_h_active | input | HW | Active pixels per line |
| cfg_h_total | input | HW | Last horizontal count of a line |
| cfg_v_sync_end | input | VW | Line at which vertical sync ends |
| cfg_v_disp_start | input | VW | First active line |
| cfg_v_irq_line | input | VW | First line after the active area; line interrupt position |
| cfg_v_total | input | VW | Last line of a frame |
| cfg_sync_pol | input | 2 | Sync polarity, bit 0 horizontal, bit 1 vertical |
| irq_mask | input | 3 | Interrupt enable per status bit |
| irq_clr | input | 3 | Write-one-to-clear strobe per status bit |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Display enable |
| px_x | output | HW | Active pixel column |
| px_y | output | VW | Active pixel row |
| line_no | output | VW | Current line count |
| irq_status | output | 3 | Sticky status: frame start, display start, line match |
| irq | output | 1 | Masked interrupt request |

## Verification
A horizontal counter that slips by one shows on `hsync` and `de` within the same line, and on `line_no` at the next line boundary. A wrong vertical count shows at once on `line_no`, and by the next line on `vsync` and `de`. A status register that drops a bit, or lets a clear beat a coincident event, differs from the expected value on the clock right after the event. Because of this, the bench compares every output on every clock against a model that derives both counts from elapsed time since reset.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  localparam int IRQ_N  = 3;
  localparam int IRQ_VS = 0;  // frame start
  localparam int IRQ_DS = 1;  // first active line
  localparam int IRQ_LN = 2;  // programmed line match

  // True when lo <= pos < lo + len.
  function automatic logic in_span(input logic [15:0] pos,
                                   input logic [15:0] lo,
                                   input logic [15:0] len);
    logic [16:0] hi;
    hi = {1'b0, lo} + {1'b0, len};
    return ({1'b0, pos} >= {1'b0, lo}) && ({1'b0, pos} < hi);
  endfunction

  // True when lo <= pos < hi.
  function automatic logic in_range(input logic [15:0] pos,
                                    input logic [15:0] lo,
                                    input logic [15:0] hi);
    return (pos >= lo) && (pos < hi);
  endfunction

  // Offset of pos from base, zero when gated off.
  function automatic logic [15:0] rel_pos(input logic [15:0] pos,
                                          input logic [15:0] base,
                                          input logic        on);
    return on ? (pos - base) : 16'd0;
  endfunction

  // Apply programmable polarity: pol=1 active high, pol=0 active low.
  function automatic logic drive_pol(input logic act, input logic pol);
    return pol ? act : ~act;
  endfunction

endpackage

// File: rtl/lcdt_hcount.sv
module lcdt_hcount #(
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] h_sync_end,
  input  logic [HW-1:0] h_disp_start,
  input  logic [HW-1:0] h_active,
  input  logic [HW-1:0] h_total,
  output logic [HW-1:0] hcnt,
  output logic          line_wrap,
  output logic          line_start,
  output logic          hs_act,
  output logic          h_in_act,
  output logic [HW-1:0] h_off
);
  import lcdt_pkg::*;

  assign line_wrap  = (hcnt >= h_total);
  assign line_start = (hcnt == '0);
  assign hs_act     = (hcnt < h_sync_end);
  assign h_in_act   = in_span(16'(hcnt), 16'(h_disp_start), 16'(h_active));
  assign h_off      = HW'(rel_pos(16'(hcnt), 16'(h_disp_start), 1'b1));

  always_ff @(posedge clk) begin
    if (!rst_n)         hcnt <= '0;
    else if (line_wrap) hcnt <= '0;
    else                hcnt <= hcnt + 1'b1;
  end

endmodule

// File: rtl/lcdt_vcount.sv
module lcdt_vcount #(
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_wrap,
  input  logic          line_start,
  input  logic [VW-1:0] v_sync_end,
  input  logic [VW-1:0] v_disp_start,
  input  logic [VW-1:0] v_irq_line,
  input  logic [VW-1:0] v_total,
  output logic [VW-1:0] vcnt,
  output logic          vs_act,
  output logic          v_in_act,
  output logic [VW-1:0] v_off,
  output logic [lcdt_pkg::IRQ_N-1:0] evt
);
  import lcdt_pkg::*;

  logic frame_wrap;

  assign frame_wrap = line_wrap && (vcnt >= v_total);
  assign vs_act     = (vcnt < v_sync_end);
  assign v_in_act   = in_range(16'(vcnt), 16'(v_disp_start), 16'(v_irq_line));
  assign v_off      = VW'(rel_pos(16'(vcnt), 16'(v_disp_start), 1'b1));

  always_comb begin
    evt         = '0;
    evt[IRQ_VS] = line_start && (vcnt == '0);
    evt[IRQ_DS] = line_start && (vcnt == v_disp_start);
    evt[IRQ_LN] = line_start && (vcnt == v_irq_line);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          vcnt <= '0;
    else if (frame_wrap) vcnt <= '0;
    else if (line_wrap)  vcnt <= vcnt + 1'b1;
  end

endmodule

// File: rtl/lcdt_irq_ctl.sv
module lcdt_irq_ctl #(
  parameter int N = lcdt_pkg::IRQ_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] status,
  output logic         irq
);

  // One sticky flop per source; an event on the clearing clock wins.
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)      status[i] <= 1'b0;
      else if (evt[i]) status[i] <= 1'b1;
      else if (clr[i]) status[i] <= 1'b0;
    end
  end

  assign irq = |(status & mask);

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] cfg_h_sync_end,
  input  logic [HW-1:0] cfg_h_disp_start,
  input  logic [HW-1:0] cfg_h_active,
  input  logic [HW-1:0] cfg_h_total,
  input  logic [VW-1:0] cfg_v_sync_end,
  input  logic [VW-1:0] cfg_v_disp_start,
  input  logic [VW-1:0] cfg_v_irq_line,
  input  logic [VW-1:0] cfg_v_total,
  input  logic [1:0]    cfg_sync_pol,
  input  logic [2:0]    irq_mask,
  input  logic [2:0]    irq_clr,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [HW-1:0] px_x,
  output logic [VW-1:0] px_y,
  output logic [VW-1:0] line_no,
  output logic [2:0]    irq_status,
  output logic          irq
);
  import lcdt_pkg::*;

  logic [HW-1:0] hcnt;
  logic [HW-1:0] h_off;
  logic [VW-1:0] vcnt;
  logic [VW-1:0] v_off;
  logic          line_wrap;
  logic          line_start;
  logic          hs_act;
  logic          vs_act;
  logic          h_in_act;
  logic          v_in_act;
  logic [IRQ_N-1:0] evt;

  lcdt_hcount #(.HW(HW)) u_h (
    .clk(clk), .rst_n(rst_n),
    .h_sync_end(cfg_h_sync_end), .h_disp_start(cfg_h_disp_start),
    .h_active(cfg_h_active), .h_total(cfg_h_total),
    .hcnt(hcnt), .line_wrap(line_wrap), .line_start(line_start),
    .hs_act(hs_act), .h_in_act(h_in_act), .h_off(h_off)
  );

  lcdt_vcount #(.VW(VW)) u_v (
    .clk(clk), .rst_n(rst_n),
    .line_wrap(line_wrap), .line_start(line_start),
    .v_sync_end(cfg_v_sync_end), .v_disp_start(cfg_v_disp_start),
    .v_irq_line(cfg_v_irq_line), .v_total(cfg_v_total),
    .vcnt(vcnt), .vs_act(vs_act), .v_in_act(v_in_act),
    .v_off(v_off), .evt(evt)
  );

  lcdt_irq_ctl #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .evt(evt), .clr(irq_clr), .mask(irq_mask),
    .status(irq_status), .irq(irq)
  );

  assign hsync   = drive_pol(hs_act, cfg_sync_pol[0]);
  assign vsync   = drive_pol(vs_act, cfg_sync_pol[1]);
  assign de      = h_in_act && v_in_act;
  assign px_x    = de ? h_off : '0;
  assign px_y    = de ? v_off : '0;
  assign line_no = vcnt;

endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic [HW-1:0] hcnt,
  input logic [HW-1:0] h_total,
  input logic [VW-1:0] vcnt,
  input logic [VW-1:0] v_total,
  input logic          line_wrap,
  input logic          hs_act,
  input logic          vs_act,
  input logic          de,
  input logic [2:0]    evt,
  input logic [2:0]    clr,
  input logic [2:0]    mask,
  input logic [2:0]    status,
  input logic          irq
);

  // R1: count advances by one inside a line
  p_hstep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt < h_total) |=> (hcnt == HW'($past(hcnt) + 1'b1)));

  // R1: count returns to zero after the last position
  p_hwrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt >= h_total) |=> (hcnt == '0));

  // R2: line held steady within a line
  p_vhold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !line_wrap |=> $stable(vcnt));

  // R2: line advances at line end
  p_vstep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_wrap && (vcnt < v_total)) |=> (vcnt == VW'($past(vcnt) + 1'b1)));

  // R4: active area never overlaps sync
  p_de_nosync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (!hs_act && !vs_act));

  // R7: frame-start event only on line zero
  p_vs_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt[0] |-> (vcnt == '0) && (hcnt == '0));

  // R10: a set bit survives when not cleared
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~clr) != 3'b000) |=>
      ((status & $past(status & ~clr)) == $past(status & ~clr)));

  // R10: event sets status on next clock even under clear
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != 3'b000) |=> ((status & $past(evt)) == $past(evt)));

  // R11: fully masked means no request
  p_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 3'b000) |-> !irq);

  // R11: no status means no request
  p_nostat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'b000) |-> !irq);

endmodule

bind lcd_timing_gen lcd_timing_gen_chk #(.HW(HW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .hcnt(hcnt), .h_total(cfg_h_total),
  .vcnt(vcnt), .v_total(cfg_v_total),
  .line_wrap(line_wrap), .hs_act(hs_act), .vs_act(vs_act),
  .de(de), .evt(evt), .clr(irq_clr), .mask(irq_mask),
  .status(irq_status), .irq(irq)
);

// File: tb/lcd_timing_gen_tb.sv
module lcd_timing_gen_tb_top;

  localparam int HW = 12;
  localparam int VW = 11;
  localparam int LIMIT = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [HW-1:0] hse = 1, hds = 2, hnp = 1, ht = 4;
  logic [VW-1:0] vse = 1, vds = 2, iln = 3, vt = 4;
  logic [1:0]    pol = 2'b11;
  logic [2:0]    msk = 3'b000;
  logic [2:0]    clr = 3'b000;
  logic          hsync, vsync, de, irq;
  logic [HW-1:0] px_x;
  logic [VW-1:0] px_y, line_no;
  logic [2:0]    irq_status;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  lcd_timing_gen #(.HW(HW), .VW(VW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_h_sync_end(hse), .cfg_h_disp_start(hds), .cfg_h_active(hnp),
    .cfg_h_total(ht), .cfg_v_sync_end(vse), .cfg_v_disp_start(vds),
    .cfg_v_irq_line(iln), .cfg_v_total(vt), .cfg_sync_pol(pol),
    .irq_mask(msk), .irq_clr(clr),
    .hsync(hsync), .vsync(vsync), .de(de), .px_x(px_x), .px_y(px_y),
    .line_no(line_no), .irq_status(irq_status), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Bench view of the raster: both counts from elapsed clocks.
  function automatic int pos_h(int t, int htot);
    return t % (htot + 1);
  endfunction
  function automatic int pos_v(int t, int htot, int vtot);
    return (t / (htot + 1)) % (vtot + 1);
  endfunction

  task automatic run_cfg(input int a_hse, input int a_hlm, input int a_hnp,
                         input int a_hrm, input int a_vse, input int a_vum,
                         input int a_vres, input int a_vlm, input int a_pol,
                         input int a_msk, input int frames);
    int ehds, eht, evds, eiln, evt, n;
    int h, v, sh, sv;
    bit e_de;
    logic [2:0] es, ev, c;
    ehds = a_hse + a_hlm;
    eht  = ehds + a_hnp + a_hrm;
    evds = a_vse + a_vum;
    eiln = evds + a_vres;
    evt  = eiln + a_vlm;
    @(negedge clk);
    rst_n = 1'b0;
    clr   = 3'b000;
    hse = HW'(a_hse); hds = HW'(ehds); hnp = HW'(a_hnp); ht = HW'(eht);
    vse = VW'(a_vse); vds = VW'(evds); iln = VW'(eiln); vt = VW'(evt);
    pol = 2'(a_pol);
    msk = 3'(a_msk);
    @(negedge clk);
    @(negedge clk);
    // R12: held reset state
    chk("R12 line_no in reset", int'(line_no), 0);
    chk("R12 status in reset", int'(irq_status), 0);
    chk("R12 irq in reset", int'(irq), 0);
    rst_n = 1'b1;
    es = 3'b000;
    n = frames * (eht + 1) * (evt + 1);
    for (int t = 0; t < n; t++) begin
      h = pos_h(t, eht);
      v = pos_v(t, eht, evt);
      sh = (h < a_hse) ? 1 : 0;
      sv = (v < a_vse) ? 1 : 0;
      e_de = (h >= ehds) && (h < ehds + a_hnp) && (v >= evds) && (v < eiln);
      chk("R1,R6 hsync", int'(hsync), a_pol[0] ? sh : 1 - sh);
      chk("R3,R6 vsync", int'(vsync), a_pol[1] ? sv : 1 - sv);
      chk("R2 line_no", int'(line_no), v);
      chk("R4 de", int'(de), int'(e_de));
      chk("R5 px_x", int'(px_x), e_de ? h - ehds : 0);
      chk("R5 px_y", int'(px_y), e_de ? v - evds : 0);
      chk("R7,R10 status frame bit", int'(irq_status[0]), int'(es[0]));
      chk("R8,R10 status display bit", int'(irq_status[1]), int'(es[1]));
      chk("R9,R10 status line bit", int'(irq_status[2]), int'(es[2]));
      chk("R11 irq", int'(irq), int'((es & 3'(a_msk)) != 3'b000));
      ev[0] = (h == 0) && (v == 0);
      ev[1] = (h == 0) && (v == evds);
      ev[2] = (h == 0) && (v == eiln);
      // Clear strobes: random, plus forced clears on event clocks (set wins)
      c = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
      if (ev != 3'b000 && ($urandom % 2) == 0) c = c | ev;
      clr = c;
      es = (es & ~c) | ev;
      @(negedge clk);
    end
    clr = 3'b000;
  endtask

  initial begin
    void'($urandom(32'd1234));
    // Directed corners: minimum sync, zero margins, interrupt line == last line
    run_cfg(1, 0, 1, 0, 1, 0, 1, 0, 3, 7, 3);
    run_cfg(1, 2, 4, 0, 1, 1, 3, 0, 0, 5, 2);
    run_cfg(3, 1, 6, 2, 2, 0, 4, 2, 1, 2, 2);
    run_cfg(2, 3, 5, 1, 1, 2, 2, 3, 2, 0, 2);
    // Constrained random
    for (int k = 0; k < 8; k++) begin
      run_cfg(1 + $urandom % 6, $urandom % 6, 1 + $urandom % 24, $urandom % 6,
              1 + $urandom % 3, $urandom % 3, 1 + $urandom % 12, $urandom % 4,
              $urandom % 4, $urandom % 8, 2);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > LIMIT);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule